// File: doc/BRIEF.md
# Load/Store Address and Load Extension Unit

This block does two jobs for a load/store pipeline stage. On its request side it takes a base register value and an offset and forms the memory address for the access, under one of three indexing rules. It also returns the value to be written back into the base register, with an enable that says whether that write should happen. The offset is scaled by a small left shift and then added to or subtracted from the base. This one path covers immediate offsets (shift 0), plain index registers and shifted index registers.

On its load side it takes a raw 32-bit word returned by memory, together with the low address bits of the access. It picks the addressed byte or halfword lane and extends it to a full register value, with zeros or with copies of its top bit. Each side is a separate valid/ready stream with a one-entry output register. A result is offered one cycle after its request is accepted. A stalled result holds still until the consumer takes it. The request side is ready whenever its output register is empty or is being emptied in the same cycle.

Top module: `ldx_unit`

## Requirements
- R1: With `a_mode` = 0 (offset), `q_addr` is base plus or minus the scaled offset and `q_wb_en` is 0.
- R2: With `a_mode` = 1 (pre-index), `q_addr` and `q_wb_data` both equal base plus or minus the scaled offset, and `q_wb_en` is 1.
- R3: With `a_mode` = 2 (post-index), `q_addr` equals the unmodified base, `q_wb_data` is base plus or minus the scaled offset, and `q_wb_en` is 1.
- R4: `a_mode` = 3 is treated exactly as offset mode: address is the computed sum and `q_wb_en` is 0.
- R5: The scaled offset is `a_offset` shifted left logically by `a_shamt` (0 to 3). `a_sub` = 1 subtracts it from the base and 0 adds it. The arithmetic is modulo 2^32. `q_wb_data` always carries this sum.
- R6: With `l_size` = 0 (byte) and `l_signed` = 0, `r_data[7:0]` is the byte at bits `8*l_addr_lo +: 8` of `l_rdata` and bits 31:8 are zero.
- R7: With `l_size` = 0 and `l_signed` = 1, the selected byte is placed in bits 7:0 and bits 31:8 are copies of its bit 7.
- R8: With `l_size` = 1 (halfword), the halfword at bits `16*l_addr_lo[1] +: 16` is placed in bits 15:0. Bits 31:16 are zero when `l_signed` = 0 and copies of bit 15 when `l_signed` = 1.
- R9: With `l_size` = 2 or 3 (word), `r_data` equals `l_rdata` regardless of `l_signed` and `l_addr_lo`.
- R10: Each side accepts a request when valid and ready are both high. The result appears on the output the next cycle, in request order. While an output is valid and not ready, its valid and data stay unchanged. `a_ready` = `!q_valid || q_ready`, and the same rule holds for the load side.
- R11: During and directly after reset, `q_valid` and `r_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Address request valid |
| a_ready | output | 1 | Address request ready |
| a_base | input | 32 | Base register value |
| a_offset | input | 32 | Immediate or index register value |
| a_shamt | input | 2 | Left shift applied to the offset |
| a_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| a_mode | input | 2 | 0 offset, 1 pre-index, 2 post-index, 3 as offset |
| q_valid | output | 1 | Address result valid |
| q_ready | input | 1 | Address result ready |
| q_addr | output | 32 | Effective memory address |
| q_wb_data | output | 32 | Value for the base register |
| q_wb_en | output | 1 | Base register write enable |
| l_valid | input | 1 | Load data valid |
| l_ready | output | 1 | Load data ready |
| l_rdata | input | 32 | Raw word read from memory |
| l_addr_lo | input | 2 | Low address bits of the access |
| l_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| l_signed | input | 1 | 1 sign-extends, 0 zero-extends |
| r_valid | output | 1 | Load result valid |
| r_ready | input | 1 | Load result ready |
| r_data | output | 32 | Extended load result |

## Verification
The bench builds the unit with its default 32-bit data width and 2-bit shift field. This puts all four byte lanes, both halfword lanes and every shift amount up to 3 in reach, along with address wraparound at the top of the 32-bit space. Both result streams first run with ready held high and then with a periodic stall pattern. The stall phase exercises the hold-while-stalled rule and the ready path back to the request side.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

  typedef enum logic [1:0] {
    IDX_OFFSET = 2'd0,
    IDX_PRE    = 2'd1,
    IDX_POST   = 2'd2,
    IDX_RSVD   = 2'd3
  } idx_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRSV = 2'd3
  } acc_size_e;

endpackage

// File: rtl/ldx_agu.sv
module ldx_agu
  import ldx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = 2
) (
  input  logic [DATA_W-1:0]  base,
  input  logic [DATA_W-1:0]  offset,
  input  logic [SHIFT_W-1:0] shamt,
  input  logic               sub,
  input  logic [1:0]         mode,
  output logic [DATA_W-1:0]  addr,
  output logic [DATA_W-1:0]  wb_data,
  output logic               wb_en
);

  logic [DATA_W-1:0] scaled;
  logic [DATA_W-1:0] sum;
  idx_mode_e         m;

  always_comb begin
    m      = idx_mode_e'(mode);
    scaled = offset << shamt;
    sum    = sub ? (base - scaled) : (base + scaled);
    wb_data = sum;
    case (m)
      IDX_PRE: begin
        addr  = sum;
        wb_en = 1'b1;
      end
      IDX_POST: begin
        addr  = base;
        wb_en = 1'b1;
      end
      default: begin
        addr  = sum;
        wb_en = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ldx_extend.sv
module ldx_extend
  import ldx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]             rdata,
  input  logic [$clog2(DATA_W/8)-1:0]   addr_lo,
  input  logic [1:0]                    size,
  input  logic                          sgn,
  output logic [DATA_W-1:0]             result
);

  localparam int NBYTE = DATA_W / 8;
  localparam int NHALF = DATA_W / 16;
  localparam int LO_W  = $clog2(NBYTE);

  logic [7:0]  byte_lane [NBYTE];
  logic [15:0] half_lane [NHALF];

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    assign byte_lane[i] = rdata[8*i +: 8];
  end

  for (genvar j = 0; j < NHALF; j++) begin : g_half
    assign half_lane[j] = rdata[16*j +: 16];
  end

  logic [7:0]      sel_b;
  logic [15:0]     sel_h;
  logic [LO_W-1:0] half_idx;
  acc_size_e       sz;

  always_comb begin
    sz       = acc_size_e'(size);
    half_idx = addr_lo >> 1;
    sel_b    = byte_lane[addr_lo];
    sel_h    = half_lane[half_idx[LO_W-2:0]];
    case (sz)
      SZ_BYTE: result = {{(DATA_W-8){sgn & sel_b[7]}}, sel_b};
      SZ_HALF: result = {{(DATA_W-16){sgn & sel_h[15]}}, sel_h};
      default: result = rdata;
    endcase
  end

endmodule

// File: rtl/ldx_slice.sv
module ldx_slice #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/ldx_unit.sv
module ldx_unit #(
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        a_valid,
  output logic                        a_ready,
  input  logic [DATA_W-1:0]           a_base,
  input  logic [DATA_W-1:0]           a_offset,
  input  logic [SHIFT_W-1:0]          a_shamt,
  input  logic                        a_sub,
  input  logic [1:0]                  a_mode,
  output logic                        q_valid,
  input  logic                        q_ready,
  output logic [DATA_W-1:0]           q_addr,
  output logic [DATA_W-1:0]           q_wb_data,
  output logic                        q_wb_en,
  input  logic                        l_valid,
  output logic                        l_ready,
  input  logic [DATA_W-1:0]           l_rdata,
  input  logic [$clog2(DATA_W/8)-1:0] l_addr_lo,
  input  logic [1:0]                  l_size,
  input  logic                        l_signed,
  output logic                        r_valid,
  input  logic                        r_ready,
  output logic [DATA_W-1:0]           r_data
);

  localparam int QW = 2 * DATA_W + 1;

  logic [DATA_W-1:0] agu_addr;
  logic [DATA_W-1:0] agu_wb;
  logic              agu_en;
  logic [QW-1:0]     q_pack;
  logic [DATA_W-1:0] ext_res;

  ldx_agu #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_agu (
    .base    (a_base),
    .offset  (a_offset),
    .shamt   (a_shamt),
    .sub     (a_sub),
    .mode    (a_mode),
    .addr    (agu_addr),
    .wb_data (agu_wb),
    .wb_en   (agu_en)
  );

  ldx_slice #(.W(QW)) u_qslice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (a_valid),
    .in_ready  (a_ready),
    .in_data   ({agu_addr, agu_wb, agu_en}),
    .out_valid (q_valid),
    .out_ready (q_ready),
    .out_data  (q_pack)
  );

  assign {q_addr, q_wb_data, q_wb_en} = q_pack;

  ldx_extend #(.DATA_W(DATA_W)) u_ext (
    .rdata   (l_rdata),
    .addr_lo (l_addr_lo),
    .size    (l_size),
    .sgn     (l_signed),
    .result  (ext_res)
  );

  ldx_slice #(.W(DATA_W)) u_rslice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (l_valid),
    .in_ready  (l_ready),
    .in_data   (ext_res),
    .out_valid (r_valid),
    .out_ready (r_ready),
    .out_data  (r_data)
  );

endmodule

// File: rtl/ldx_unit_chk.sv
module ldx_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_valid,
  input logic              a_ready,
  input logic [DATA_W-1:0] a_base,
  input logic [1:0]        a_mode,
  input logic              q_valid,
  input logic              q_ready,
  input logic [DATA_W-1:0] q_addr,
  input logic [DATA_W-1:0] q_wb_data,
  input logic              q_wb_en,
  input logic              l_valid,
  input logic              l_ready,
  input logic [1:0]        l_size,
  input logic              l_signed,
  input logic              r_valid,
  input logic              r_ready,
  input logic [DATA_W-1:0] r_data
);

  // R1 R4
  no_wb_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && (a_mode == 2'd0 || a_mode == 2'd3)) |=> (q_valid && !q_wb_en));

  // R2
  pre_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && a_mode == 2'd1) |=> (q_wb_en && q_addr == q_wb_data));

  // R3
  post_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && a_mode == 2'd2) |=> (q_wb_en && q_addr == $past(a_base)));

  // R6
  ubyte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_valid && l_ready && l_size == 2'd0 && !l_signed) |=> (r_data[DATA_W-1:8] == '0));

  // R7
  sbyte_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_valid && l_ready && l_size == 2'd0 && l_signed) |=> (r_data[DATA_W-1:8] == {(DATA_W-8){r_data[7]}}));

  // R10
  q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> (q_valid && $stable(q_addr) && $stable(q_wb_data) && $stable(q_wb_en)));

  // R10
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data)));

  // R11
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!q_valid && !r_valid));

endmodule

bind ldx_unit ldx_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_valid   (a_valid),
  .a_ready   (a_ready),
  .a_base    (a_base),
  .a_mode    (a_mode),
  .q_valid   (q_valid),
  .q_ready   (q_ready),
  .q_addr    (q_addr),
  .q_wb_data (q_wb_data),
  .q_wb_en   (q_wb_en),
  .l_valid   (l_valid),
  .l_ready   (l_ready),
  .l_size    (l_size),
  .l_signed  (l_signed),
  .r_valid   (r_valid),
  .r_ready   (r_ready),
  .r_data    (r_data)
);

// File: tb/tb_ldx_unit.sv
module tb_ldx_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_valid = 1'b0;
  logic        a_ready;
  logic [31:0] a_base = '0;
  logic [31:0] a_offset = '0;
  logic [1:0]  a_shamt = '0;
  logic        a_sub = 1'b0;
  logic [1:0]  a_mode = '0;
  logic        q_valid;
  logic        q_ready = 1'b1;
  logic [31:0] q_addr;
  logic [31:0] q_wb_data;
  logic        q_wb_en;
  logic        l_valid = 1'b0;
  logic        l_ready;
  logic [31:0] l_rdata = '0;
  logic [1:0]  l_addr_lo = '0;
  logic [1:0]  l_size = '0;
  logic        l_signed = 1'b0;
  logic        r_valid;
  logic        r_ready = 1'b1;
  logic [31:0] r_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit bp     = 1'b0;

  logic [64:0] qexp[$];
  string       qtag[$];
  logic [31:0] rexp[$];
  string       rtag[$];

  always #4 clk = ~clk;

  ldx_unit dut (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_base(a_base), .a_offset(a_offset),
    .a_shamt(a_shamt), .a_sub(a_sub), .a_mode(a_mode),
    .q_valid(q_valid), .q_ready(q_ready), .q_addr(q_addr), .q_wb_data(q_wb_data),
    .q_wb_en(q_wb_en),
    .l_valid(l_valid), .l_ready(l_ready), .l_rdata(l_rdata), .l_addr_lo(l_addr_lo),
    .l_size(l_size), .l_signed(l_signed),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data)
  );

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, got cycle %0d exp below 20000", cyc);
      report();
    end
  end

  // scoreboard monitor: decide ready for the coming edge, compare on handshake
  logic        q_hold = 1'b0;
  logic [64:0] q_held;
  logic        r_hold = 1'b0;
  logic [31:0] r_held;

  always @(negedge clk) begin
    bit qr, rr;
    logic [64:0] e;
    string t;
    qr = !bp || (cyc % 3 != 0);
    rr = !bp || (cyc % 4 != 1);
    if (rst_n) begin
      if (q_hold) begin
        checks++;
        if (!q_valid || {q_addr, q_wb_data, q_wb_en} != q_held) begin
          fails++;
          $display("FAIL R10: stalled addr result moved, got %h/%h exp %h", q_valid,
                   {q_addr, q_wb_data, q_wb_en}, q_held);
        end
      end
      if (r_hold) begin
        checks++;
        if (!r_valid || r_data != r_held) begin
          fails++;
          $display("FAIL R10: stalled load result moved, got %h/%h exp %h", r_valid, r_data, r_held);
        end
      end
      q_hold = q_valid && !qr;
      q_held = {q_addr, q_wb_data, q_wb_en};
      r_hold = r_valid && !rr;
      r_held = r_data;
      if (q_valid && qr) begin
        checks++;
        if (qexp.size() == 0) begin
          fails++;
          $display("FAIL R10: unexpected addr result, got %h exp none", {q_addr, q_wb_data, q_wb_en});
        end else begin
          e = qexp.pop_front();
          t = qtag.pop_front();
          if ({q_addr, q_wb_data, q_wb_en} != e) begin
            fails++;
            $display("FAIL %s: addr/wb/en got %h %h %b exp %h %h %b", t, q_addr, q_wb_data, q_wb_en,
                     e[64:33], e[32:1], e[0]);
          end
        end
      end
      if (r_valid && rr) begin
        checks++;
        if (rexp.size() == 0) begin
          fails++;
          $display("FAIL R10: unexpected load result, got %h exp none", r_data);
        end else begin
          t = rtag.pop_front();
          if (r_data != rexp[0]) begin
            fails++;
            $display("FAIL %s: load result got %h exp %h", t, r_data, rexp[0]);
          end
          void'(rexp.pop_front());
        end
      end
    end
    q_ready = qr;
    r_ready = rr;
  end

  task automatic send_a(input logic [31:0] b, input logic [31:0] o, input logic [1:0] sh,
                        input logic s, input logic [1:0] m, input string tag);
    logic [31:0] sc, sum, ad;
    logic        en;
    sc  = o << sh;
    sum = s ? b - sc : b + sc;
    ad  = (m == 2'd2) ? b : sum;
    en  = (m == 2'd1) || (m == 2'd2);
    qexp.push_back({ad, sum, en});
    qtag.push_back(tag);
    @(negedge clk);
    a_valid = 1'b1; a_base = b; a_offset = o; a_shamt = sh; a_sub = s; a_mode = m;
    #2;
    while (!a_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1 a_valid = 1'b0;
  endtask

  task automatic send_l(input logic [31:0] rd, input logic [1:0] lo, input logic [1:0] sz,
                        input logic sg, input string tag);
    logic [31:0] ex;
    logic [7:0]  b8;
    logic [15:0] h16;
    b8  = rd[8*lo +: 8];
    h16 = rd[16*lo[1] +: 16];
    if (sz == 2'd0)      ex = (sg && b8[7]) ? {24'hFFFFFF, b8} : {24'h0, b8};
    else if (sz == 2'd1) ex = (sg && h16[15]) ? {16'hFFFF, h16} : {16'h0, h16};
    else                 ex = rd;
    rexp.push_back(ex);
    rtag.push_back(tag);
    @(negedge clk);
    l_valid = 1'b1; l_rdata = rd; l_addr_lo = lo; l_size = sz; l_signed = sg;
    #2;
    while (!l_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1 l_valid = 1'b0;
  endtask

  task automatic run_all;
    send_a(32'h0000_1000, 32'h10, 2'd0, 1'b0, 2'd0, "R1");
    send_a(32'h0000_2000, 32'h3,  2'd2, 1'b1, 2'd0, "R5");
    send_a(32'h0000_0100, 32'h20, 2'd1, 1'b0, 2'd1, "R2");
    send_a(32'h0000_0400, 32'h8,  2'd0, 1'b0, 2'd2, "R3");
    send_a(32'h0000_0080, 32'h1,  2'd3, 1'b1, 2'd2, "R3");
    send_a(32'h0000_0010, 32'h4,  2'd0, 1'b0, 2'd3, "R4");
    send_a(32'hFFFF_FFFC, 32'h8,  2'd0, 1'b0, 2'd1, "R5");
    send_a(32'h0000_0004, 32'h2,  2'd3, 1'b1, 2'd2, "R5");
    send_l(32'h80FF_7F12, 2'd0, 2'd0, 1'b0, "R6");
    send_l(32'h80FF_7F12, 2'd3, 2'd0, 1'b0, "R6");
    send_l(32'h80FF_7F12, 2'd1, 2'd0, 1'b1, "R7");
    send_l(32'h80FF_7F12, 2'd2, 2'd0, 1'b1, "R7");
    send_l(32'h80FF_7F12, 2'd3, 2'd0, 1'b1, "R7");
    send_l(32'h80FF_7F12, 2'd0, 2'd1, 1'b1, "R8");
    send_l(32'h80FF_7F12, 2'd2, 2'd1, 1'b1, "R8");
    send_l(32'h80FF_7F12, 2'd2, 2'd1, 1'b0, "R8");
    send_l(32'h80FF_7F12, 2'd1, 2'd2, 1'b1, "R9");
    send_l(32'h80FF_7F12, 2'd3, 2'd3, 1'b0, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (q_valid !== 1'b0 || r_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11: valids in reset got %b%b exp 00", q_valid, r_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (q_valid !== 1'b0 || r_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11: valids after reset got %b%b exp 00", q_valid, r_valid);
    end
    run_all();
    bp = 1'b1;
    run_all();
    for (int i = 0; i < 4; i++) begin
      send_a(32'h1000_0000 + i, 32'h40, 2'(i), 1'(i), 2'(i), "R10");
      send_l(32'hC3A5_5A3C, 2'(i), 2'(i), 1'(i), "R10");
    end
    for (int i = 0; i < 200 && (qexp.size() != 0 || rexp.size() != 0); i++) @(negedge clk);
    bp = 1'b0;
    for (int i = 0; i < 50 && (qexp.size() != 0 || rexp.size() != 0); i++) @(negedge clk);
    checks++;
    if (qexp.size() != 0 || rexp.size() != 0) begin
      fails++;
      $display("FAIL R10: results missing, got %0d/%0d pending exp 0/0", qexp.size(), rexp.size());
    end
    report();
  end

endmodule